// File: doc/BRIEF.md
# Breakpoint Acknowledge Sequencer

This block sits beside the instruction decoder and watches each instruction word offered to execution. A word in the software-breakpoint group (sixteen-bit values 16'h4848 up to 16'h484F) does not run as an ordinary instruction. Instead, the block stops accepting instructions and runs one acknowledge read transfer on a small external bus. The bus address carries the breakpoint number taken from the word's three lowest bits, so debug hardware can tell which breakpoint was hit.

External logic ends the transfer with either a good-completion input or a fault input. Both are treated the same way: one cycle later the block sends a one-cycle illegal-instruction exception request to the exception unit. It then goes idle and accepts instructions again. Vector fetch and stacking belong to the exception unit and are not handled here.

Top module: `bkpt_ack_seq`

## Requirements
- R1: An offered word (`instr_valid` high while `instr_ready` is high) whose value is 16'h4848 to 16'h484F is accepted, and in the next cycle `bus_start` is high.
- R2: An accepted word outside that range causes no transfer and no exception request.
- R3: While `bus_cyc` is high, `bus_addr` equals the accepted word's bits [2:0], zero-extended, and does not change. Outside a transfer it is zero.
- R4: While `bus_cyc` is high, `bus_rd` is 1, `bus_ttype` equals the acknowledge code (default 2'b11) and `bus_tmod` is 3'b000. Outside a transfer, `bus_rd` and `bus_ttype` are zero.
- R5: `bus_start` is high only in the first cycle of a transfer. `bus_cyc` is high from that cycle and stays high until a termination is sampled.
- R6: `term_ok` high in a transfer cycle after the first one ends the transfer. `exc_illegal` is high in the next cycle.
- R7: `term_err` ends the transfer in the same way, and also produces the exception request.
- R8: `exc_illegal` lasts exactly one cycle per breakpoint, even when `term_ok` and `term_err` are high together. The cycle after it is idle with `instr_ready` high.
- R9: `instr_ready` is low from the cycle after a breakpoint is accepted until the cycle after the exception request. Words offered during that time are ignored.
- R10: `term_ok` and `term_err` are ignored while idle and in the first transfer cycle.
- R11: After reset, `instr_ready` is 1 and all bus outputs and `exc_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Decoder offers `instr_word` |
| instr_word | input | 16 | Instruction word |
| instr_ready | output | 1 | Block accepts an instruction this cycle |
| bus_start | output | 1 | First cycle of the acknowledge transfer |
| bus_cyc | output | 1 | Transfer in progress |
| bus_rd | output | 1 | Read direction |
| bus_ttype | output | TT_W | Transfer type |
| bus_tmod | output | TM_W | Transfer modifier |
| bus_addr | output | AW | Breakpoint number, zero-extended |
| term_ok | input | 1 | Normal termination |
| term_err | input | 1 | Error termination |
| exc_illegal | output | 1 | Illegal-instruction exception request, one-cycle pulse |

## Verification
Two events can fall in the same cycle: the good and the faulty termination can arrive together, and a termination can coincide with the first cycle of a transfer. The bench drives both inputs high together in the wait phase, and also raises the terminations during the first transfer cycle and while idle. A reference model, updated every cycle, sets the outcome: one transfer end and one exception pulse. The bench also counts pulses, so a duplicate request or a premature end is reported.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
   localparam int unsigned BKPT_NUM_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ADDR  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RAISE = 2'd3
   } bkpt_state_e;
endpackage

// File: rtl/bkpt_match.sv
module bkpt_match
   import bkpt_pkg::*;
#(
   parameter int unsigned  IW        = 16,
   parameter logic [15:0]  BKPT_BASE = 16'h4848
) (
   input  logic [IW-1:0]         word,
   output logic                  hit,
   output logic [BKPT_NUM_W-1:0] num
);
   localparam int unsigned TAG_W = IW - BKPT_NUM_W;
   localparam logic [IW-1:0] BASE_X = IW'(BKPT_BASE);

   // the group is aligned to eight, so the tag compare covers the whole range
   assign hit = (word[IW-1:BKPT_NUM_W] == BASE_X[IW-1:BKPT_NUM_W]);
   assign num = word[BKPT_NUM_W-1:0];

   if (TAG_W < 1) begin : g_bad_width
      $error("bkpt_match: IW too small");
   end
endmodule

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
   import bkpt_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  offer_hit,
   input  logic [BKPT_NUM_W-1:0] offer_num,
   input  logic                  term_ok,
   input  logic                  term_err,
   output bkpt_state_e           state,
   output logic [BKPT_NUM_W-1:0] num_q
);
   bkpt_state_e state_d;
   logic        any_term;

   assign any_term = term_ok | term_err;

   always_comb begin
      state_d = state;
      unique case (state)
         ST_IDLE:  if (offer_hit) state_d = ST_ADDR;
         ST_ADDR:  state_d = ST_WAIT;
         ST_WAIT:  if (any_term) state_d = ST_RAISE;
         ST_RAISE: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         num_q <= '0;
      end else begin
         state <= state_d;
         if (state == ST_IDLE && offer_hit) num_q <= offer_num;
      end
   end
endmodule

// File: rtl/bkpt_bus_drv.sv
module bkpt_bus_drv
   import bkpt_pkg::*;
#(
   parameter int unsigned     AW        = 32,
   parameter int unsigned     TT_W      = 2,
   parameter int unsigned     TM_W      = 3,
   parameter logic [TT_W-1:0] ACK_TTYPE = 2'b11
) (
   input  bkpt_state_e           state,
   input  logic [BKPT_NUM_W-1:0] num_q,
   output logic                  instr_ready,
   output logic                  bus_start,
   output logic                  bus_cyc,
   output logic                  bus_rd,
   output logic [TT_W-1:0]       bus_ttype,
   output logic [TM_W-1:0]       bus_tmod,
   output logic [AW-1:0]         bus_addr,
   output logic                  exc_illegal
);
   localparam int unsigned PAD_W = AW - BKPT_NUM_W;

   logic active;

   assign active      = (state == ST_ADDR) || (state == ST_WAIT);
   assign instr_ready = (state == ST_IDLE);
   assign bus_start   = (state == ST_ADDR);
   assign bus_cyc     = active;
   assign bus_rd      = active;
   assign bus_ttype   = active ? ACK_TTYPE : '0;
   assign bus_tmod    = '0;
   assign exc_illegal = (state == ST_RAISE);

   if (PAD_W > 0) begin : g_pad
      assign bus_addr = active ? {{PAD_W{1'b0}}, num_q} : '0;
   end else begin : g_exact
      assign bus_addr = active ? num_q : '0;
   end
endmodule

// File: rtl/bkpt_ack_seq.sv
module bkpt_ack_seq
   import bkpt_pkg::*;
#(
   parameter int unsigned     IW        = 16,
   parameter int unsigned     AW        = 32,
   parameter int unsigned     TT_W      = 2,
   parameter int unsigned     TM_W      = 3,
   parameter logic [TT_W-1:0] ACK_TTYPE = 2'b11,
   parameter logic [15:0]     BKPT_BASE = 16'h4848
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [IW-1:0]   instr_word,
   output logic            instr_ready,
   output logic            bus_start,
   output logic            bus_cyc,
   output logic            bus_rd,
   output logic [TT_W-1:0] bus_ttype,
   output logic [TM_W-1:0] bus_tmod,
   output logic [AW-1:0]   bus_addr,
   input  logic            term_ok,
   input  logic            term_err,
   output logic            exc_illegal
);
   if (AW < BKPT_NUM_W) begin : g_chk_aw
      $error("bkpt_ack_seq: AW must hold the breakpoint number");
   end
   if (BKPT_BASE[BKPT_NUM_W-1:0] != '0) begin : g_chk_base
      $error("bkpt_ack_seq: BKPT_BASE must be aligned to eight");
   end
   if (ACK_TTYPE == '0) begin : g_chk_tt
      $error("bkpt_ack_seq: ACK_TTYPE must differ from the idle code");
   end

   logic                  word_hit;
   logic [BKPT_NUM_W-1:0] word_num;
   bkpt_state_e           state;
   logic [BKPT_NUM_W-1:0] num_q;

   bkpt_match #(.IW(IW), .BKPT_BASE(BKPT_BASE)) u_match (
      .word (instr_word),
      .hit  (word_hit),
      .num  (word_num)
   );

   bkpt_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .offer_hit (instr_valid & word_hit),
      .offer_num (word_num),
      .term_ok   (term_ok),
      .term_err  (term_err),
      .state     (state),
      .num_q     (num_q)
   );

   bkpt_bus_drv #(.AW(AW), .TT_W(TT_W), .TM_W(TM_W), .ACK_TTYPE(ACK_TTYPE)) u_drv (
      .state       (state),
      .num_q       (num_q),
      .instr_ready (instr_ready),
      .bus_start   (bus_start),
      .bus_cyc     (bus_cyc),
      .bus_rd      (bus_rd),
      .bus_ttype   (bus_ttype),
      .bus_tmod    (bus_tmod),
      .bus_addr    (bus_addr),
      .exc_illegal (exc_illegal)
   );
endmodule

// File: rtl/bkpt_ack_seq_chk.sv
module bkpt_ack_seq_chk #(
   parameter int unsigned     IW        = 16,
   parameter int unsigned     AW        = 32,
   parameter int unsigned     TT_W      = 2,
   parameter int unsigned     TM_W      = 3,
   parameter logic [TT_W-1:0] ACK_TTYPE = 2'b11,
   parameter logic [15:0]     BKPT_BASE = 16'h4848
) (
   input logic            clk,
   input logic            rst_n,
   input logic            instr_valid,
   input logic [IW-1:0]   instr_word,
   input logic            instr_ready,
   input logic            bus_start,
   input logic            bus_cyc,
   input logic            bus_rd,
   input logic [TT_W-1:0] bus_ttype,
   input logic [TM_W-1:0] bus_tmod,
   input logic [AW-1:0]   bus_addr,
   input logic            term_ok,
   input logic            term_err,
   input logic            exc_illegal
);
   localparam logic [IW-1:0] BASE_X = IW'(BKPT_BASE);

   logic in_group;
   assign in_group = (instr_word[IW-1:3] == BASE_X[IW-1:3]);

   assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_ready && in_group) |=> bus_start);

   assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_ready && !in_group) |=> (!bus_cyc && !exc_illegal));

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_start) |-> $stable(bus_addr));

   assert_attrs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc |-> (bus_rd && bus_ttype == ACK_TTYPE && bus_tmod == '0));

   assert_start_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (bus_cyc && !bus_start));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_start && !term_ok && !term_err) |=> bus_cyc);

   assert_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_start && (term_ok || term_err)) |=> (exc_illegal && !bus_cyc));

   assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_illegal |=> (!exc_illegal && instr_ready));

   assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc || exc_illegal) |-> !instr_ready);

   assert_idle_term_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_ready && !instr_valid) |=> (!bus_cyc && !exc_illegal));
endmodule

bind bkpt_ack_seq bkpt_ack_seq_chk #(
   .IW(IW), .AW(AW), .TT_W(TT_W), .TM_W(TM_W),
   .ACK_TTYPE(ACK_TTYPE), .BKPT_BASE(BKPT_BASE)
) u_chk (.*);

// File: tb/tb_bkpt_ack_seq.sv
`timescale 1ns/1ps
module tb_bkpt_ack_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr_word = '0;
   logic        term_ok = 1'b0;
   logic        term_err = 1'b0;
   logic        instr_ready, bus_start, bus_cyc, bus_rd, exc_illegal;
   logic [1:0]  bus_ttype;
   logic [2:0]  bus_tmod;
   logic [31:0] bus_addr;

   int n_checks = 0;
   int n_fail = 0;
   int exc_count = 0;
   int start_count = 0;
   bit done = 0;

   // reference model: phase 0 idle, 1 first transfer cycle, 2 waiting, 3 request
   int m_phase = 0;
   int m_num = 0;

   always #2 clk = ~clk;

   bkpt_ack_seq dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .instr_ready(instr_ready), .bus_start(bus_start), .bus_cyc(bus_cyc),
      .bus_rd(bus_rd), .bus_ttype(bus_ttype), .bus_tmod(bus_tmod),
      .bus_addr(bus_addr), .term_ok(term_ok), .term_err(term_err),
      .exc_illegal(exc_illegal)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase <= 0;
      end else begin
         case (m_phase)
            0: if (instr_valid && instr_word >= 16'h4848 && instr_word <= 16'h484F) begin
                  m_phase <= 1;
                  m_num   <= int'(instr_word & 16'h7);
               end
            1: m_phase <= 2;
            2: if (term_ok || term_err) m_phase <= 3;
            default: m_phase <= 0;
         endcase
      end
   end

   task automatic check(string tag, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit xfer;
      xfer = (m_phase == 1 || m_phase == 2);
      check("R9 instr_ready", instr_ready, m_phase == 0);
      check("R5 bus_start", bus_start, m_phase == 1);
      check("R5 bus_cyc", bus_cyc, xfer);
      check("R4 bus_rd", bus_rd, xfer);
      check("R4 bus_ttype", bus_ttype, xfer ? 3 : 0);
      check("R4 bus_tmod", bus_tmod, 0);
      check("R3 bus_addr", bus_addr, xfer ? m_num : 0);
      check("R6 exc_illegal", exc_illegal, m_phase == 3);
   endtask

   task automatic step(bit v, logic [15:0] w, bit ok, bit err);
      @(negedge clk);
      compare_all();
      if (exc_illegal) exc_count++;
      if (bus_start) start_count++;
      instr_valid = v;
      instr_word  = w;
      term_ok     = ok;
      term_err    = err;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 16'h0, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int e0;
      int s0;
      repeat (2) @(negedge clk);
      // R11 reset values
      check("R11 ready", instr_ready, 1);
      check("R11 cyc", bus_cyc, 0);
      check("R11 exc", exc_illegal, 0);
      check("R11 addr", bus_addr, 0);
      rst_n = 1'b1;
      idle(2);

      // R10 terminations while idle
      e0 = exc_count; s0 = start_count;
      step(0, 16'h0, 1, 0); step(0, 16'h0, 0, 1); step(0, 16'h0, 1, 1);
      idle(3);
      check("R10 idle term exc", exc_count, e0);
      check("R10 idle term start", start_count, s0);

      // R1 R3 R6 every breakpoint number, term_ok raised in first cycle (R10)
      for (int n = 0; n < 8; n++) begin
         e0 = exc_count;
         step(1, 16'h4848 + 16'(n), 0, 0);
         step(0, 16'h0, 1, 0);
         for (int k = 0; k < n; k++) step(0, 16'h0, 0, 0);
         step(0, 16'h0, 1, 0);
         idle(3);
         check("R1 one request per breakpoint", exc_count, e0 + 1);
      end

      // R7 fault termination
      e0 = exc_count;
      step(1, 16'h484D, 0, 0);
      idle(2);
      step(0, 16'h0, 0, 1);
      idle(3);
      check("R7 fault ends with request", exc_count, e0 + 1);

      // R8 both terminations together
      e0 = exc_count;
      step(1, 16'h484B, 0, 0);
      step(0, 16'h0, 0, 0);
      step(0, 16'h0, 1, 1);
      idle(4);
      check("R8 single request", exc_count, e0 + 1);

      // R9 words offered while busy are ignored
      e0 = exc_count; s0 = start_count;
      step(1, 16'h484A, 0, 0);
      step(1, 16'h4849, 0, 0);
      step(1, 16'h4849, 0, 0);
      step(1, 16'h4849, 1, 0);
      step(0, 16'h0, 0, 0);
      idle(4);
      check("R9 one transfer", start_count, s0 + 1);
      check("R9 one request", exc_count, e0 + 1);

      // R2 words outside the group
      e0 = exc_count; s0 = start_count;
      step(1, 16'h4847, 0, 0);
      step(1, 16'h4850, 0, 0);
      step(1, 16'hC848, 0, 0);
      step(1, 16'h0848, 0, 0);
      step(1, 16'h0000, 0, 0);
      idle(4);
      check("R2 no transfer", start_count, s0);
      check("R2 no request", exc_count, e0);

      // back-to-back breakpoint accepted on return to idle
      e0 = exc_count;
      step(1, 16'h484F, 0, 0);
      step(0, 16'h0, 0, 0);
      step(0, 16'h0, 0, 1);
      step(1, 16'h4848, 0, 0);
      step(1, 16'h4848, 0, 0);
      step(0, 16'h0, 0, 0);
      step(0, 16'h0, 1, 0);
      idle(3);
      check("R1 back-to-back requests", exc_count, e0 + 2);

      finish_run();
   end
endmodule